// File: doc/BRIEF.md
# Wilkinson Shift and Deflation Unit

This unit sits beside the QR step of a symmetric eigenvalue iteration. It keeps the size of the active (still unconverged) leading submatrix of the iteration matrix. It reaches that matrix through a combinational register-file read port and a diagonal write port. On a shift command it first tests whether the last row of the active region has converged. If it has, it shrinks the active size by one. It then reads the trailing 2×2 entries `[a b; b c]` of the active region and computes the Wilkinson shift `mu` in Q16.16 fixed point. Finally it subtracts `mu` from every active diagonal entry, so that the QR step can run.

After the QR step has formed R·Q, a restore command adds the same `mu` back to the active diagonal. The square root and the division run on iterative units, so one shift command takes roughly a hundred cycles. When the active size reaches one, every eigenvalue has been deflated. The unit then raises `all_conv` and produces no further shift.

Top module: `wk_shift_unit`

## Requirements
- R1: After reset, `act_size` equals N (4 by default), and `all_conv`, `done` and `busy` are 0; `mu` is 0.
- R2: On a shift command (`cmd`=0) with k=`act_size`>1, the unit tests every entry M[k-1][j] for j<k-1. If every magnitude is strictly below the unsigned threshold `thr`, `act_size` drops by exactly one. One command deflates at most once.
- R3: The shift uses the active size k after that test: a=M[k-2][k-2], b=M[k-1][k-2], c=M[k-1][k-1], with `rd_row` giving the row index and `rd_col` the column index.
- R4: All values are two's complement Q16.16. delta=floor((a-c)/2). d2 and b2 are the squares of delta and b, shifted right by 16. s=floor(sqrt((d2+b2)·2^16)). den=|delta|+s. q=floor(b2·2^16/den). The result is mu=c-q when delta≥0 and mu=c+q when delta<0.
- R5: When delta is zero the sign is taken as +1 (mu=c-q). When den is zero, mu=c.
- R6: After computing mu, a shift command writes M[i][i]-mu for every i<k and leaves every other matrix entry unchanged.
- R7: A restore command (`cmd`=1) writes M[i][i]+mu for every i<`act_size`, using the stored mu, and changes nothing else.
- R8: When a deflation brings `act_size` to 1, `all_conv` rises and stays high until reset. From then on no command writes the matrix or changes `mu`.
- R9: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse that ends every command. A `start` raised while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command when idle |
| cmd | input | 1 | 0 = deflate, compute and subtract shift; 1 = add shift back |
| thr | input | W | Unsigned convergence threshold (Q16.16 magnitude) |
| rd_row | output | log2(N) | Read row index |
| rd_col | output | log2(N) | Read column index |
| rd_data | input | W | Matrix entry at (rd_row, rd_col), same cycle |
| wr_en | output | 1 | Diagonal write strobe |
| wr_idx | output | log2(N) | Diagonal position written |
| wr_data | output | W | Value written to M[wr_idx][wr_idx] |
| mu | output | W | Current shift, Q16.16 |
| act_size | output | log2(N+1) | Size of the active submatrix |
| all_conv | output | 1 | All eigenvalues deflated |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished pulse |

## Verification
The hardest states to reach are a deflation immediately followed by a shift taken from the smaller region, and a sequence of deflations that drives the active size down to one. Random trials therefore fill the last active row with values below the threshold on about half of the commands, so that the active size walks down across runs. A directed run on an all-zero matrix steps through every size down to convergence and then issues extra commands. Directed entries with a equal to c cover the zero-delta sign rule and the zero-denominator case, and a threshold of zero forces the no-deflation path.

// File: rtl/wk_shift_pkg.sv
package wk_shift_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_RDA, S_RDB, S_RDC, S_PREP,
    S_ROOT, S_DIV, S_MU, S_APPLY, S_DONE
  } wk_state_t;

  localparam logic CMD_SHIFT   = 1'b0;
  localparam logic CMD_RESTORE = 1'b1;
endpackage

// File: rtl/wk_isqrt.sv
// Digit-by-digit integer square root, one result bit per cycle.
module wk_isqrt #(
  parameter int RW = 64,
  localparam int HW = RW / 2,
  localparam int MW = HW + 3,
  localparam int CW = $clog2(HW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [RW-1:0] rad,
  output logic [HW-1:0] root,
  output logic          done
);
  logic [RW-1:0] sh_q, sh_d;
  logic [MW-1:0] rem_q, rem_d;
  logic [HW-1:0] root_q, root_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, done_q, done_d;
  logic [MW-1:0] rem_sh, trial;
  logic          ge;

  assign rem_sh = {rem_q[MW-3:0], sh_q[RW-1:RW-2]};
  assign trial  = MW'({root_q, 2'b01});
  assign ge     = rem_sh >= trial;

  always_comb begin
    sh_d = sh_q; rem_d = rem_q; root_d = root_q;
    cnt_d = cnt_q; run_d = run_q; done_d = 1'b0;
    if (go) begin
      sh_d = rad; rem_d = '0; root_d = '0;
      cnt_d = CW'(HW); run_d = 1'b1;
    end else if (run_q) begin
      sh_d   = {sh_q[RW-3:0], 2'b00};
      rem_d  = ge ? rem_sh - trial : rem_sh;
      root_d = {root_q[HW-2:0], ge};
      cnt_d  = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d = 1'b0; done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; rem_q <= '0; root_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      sh_q <= sh_d; rem_q <= rem_d; root_q <= root_d;
      cnt_q <= cnt_d; run_q <= run_d; done_q <= done_d;
    end
  end

  assign root = root_q;
  assign done = done_q;
endmodule

// File: rtl/wk_udiv.sv
// Shift-subtract unsigned divider, one quotient bit per cycle.
module wk_udiv #(
  parameter int DW = 64,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quot,
  output logic          done
);
  logic [DW:0]   rem_q, rem_d;
  logic [DW-1:0] q_q, q_d, dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, done_q, done_d;
  logic [DW:0]   rem_sh, diff;

  assign rem_sh = {rem_q[DW-1:0], q_q[DW-1]};
  assign diff   = rem_sh - {1'b0, dvs_q};

  always_comb begin
    rem_d = rem_q; q_d = q_q; dvs_d = dvs_q;
    cnt_d = cnt_q; run_d = run_q; done_d = 1'b0;
    if (go) begin
      rem_d = '0; q_d = dividend; dvs_d = divisor;
      cnt_d = CW'(DW); run_d = 1'b1;
    end else if (run_q) begin
      if (!diff[DW]) begin
        rem_d = diff;   q_d = {q_q[DW-2:0], 1'b1};
      end else begin
        rem_d = rem_sh; q_d = {q_q[DW-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d = 1'b0; done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; q_q <= '0; dvs_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      rem_q <= rem_d; q_q <= q_d; dvs_q <= dvs_d;
      cnt_q <= cnt_d; run_q <= run_d; done_q <= done_d;
    end
  end

  assign quot = q_q;
  assign done = done_q;
endmodule

// File: rtl/wk_shift_unit.sv
module wk_shift_unit
  import wk_shift_pkg::*;
#(
  parameter int N    = 4,
  parameter int W    = 32,
  parameter int FRAC = 16,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1,
  localparam int AW   = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            cmd,
  input  logic [W-1:0]    thr,
  output logic [IDXW-1:0] rd_row,
  output logic [IDXW-1:0] rd_col,
  input  logic [W-1:0]    rd_data,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [W-1:0]    wr_data,
  output logic [W-1:0]    mu,
  output logic [AW-1:0]   act_size,
  output logic            all_conv,
  output logic            busy,
  output logic            done
);
  localparam int PW = 2 * W;

  wk_state_t st_q, st_d;
  logic [IDXW-1:0]     j_q, j_d;
  logic [AW-1:0]       act_q, act_d;
  logic signed [W-1:0] a_q, a_d, b_q, b_d, c_q, c_d, mu_q, mu_d;
  logic                sub_q, sub_d, small_q, small_d, conv_q, conv_d, zden_q, zden_d;

  // trailing-corner indices of the active region
  logic [IDXW-1:0] last_idx, prev_idx;
  assign last_idx = IDXW'(act_q - AW'(1));
  assign prev_idx = IDXW'(act_q - AW'(2));

  // off-diagonal magnitude test
  logic [W:0] mag;
  logic       is_small;
  assign mag      = rd_data[W-1] ? ({1'b0, ~rd_data} + 1'b1) : {1'b0, rd_data};
  assign is_small = mag < {1'b0, thr};

  // shift arithmetic
  logic [W:0]           diff_ac;
  logic signed [W-1:0]  delta;
  logic signed [PW-1:0] dx, bx, dsq, bsq;
  logic [PW-1:0]        d2, b2, rad, den, dividend;
  logic [W-1:0]         abs_delta, root, qv;
  logic [PW-1:0]        quot;
  logic                 sq_done, dv_done, sq_go, dv_go;

  assign diff_ac   = {a_q[W-1], a_q} - {c_q[W-1], c_q};
  assign delta     = diff_ac[W:1];
  assign dx        = PW'(delta);
  assign bx        = PW'(b_q);
  assign dsq       = dx * dx;
  assign bsq       = bx * bx;
  assign d2        = $unsigned(dsq) >> FRAC;
  assign b2        = $unsigned(bsq) >> FRAC;
  assign rad       = (d2 + b2) << FRAC;
  assign abs_delta = delta[W-1] ? $unsigned(-delta) : $unsigned(delta);
  assign den       = PW'(abs_delta) + PW'(root);
  assign dividend  = b2 << FRAC;
  assign sq_go     = (st_q == S_PREP);
  assign dv_go     = (st_q == S_ROOT) && sq_done && (den != '0);
  assign qv        = zden_q ? '0 : quot[W-1:0];

  wk_isqrt #(.RW(PW)) u_root (
    .clk(clk), .rst_n(rst_n), .go(sq_go), .rad(rad), .root(root), .done(sq_done)
  );

  wk_udiv #(.DW(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(dv_go), .dividend(dividend), .divisor(den),
    .quot(quot), .done(dv_done)
  );

  // read address selection
  always_comb begin
    rd_row = '0; rd_col = '0;
    unique case (st_q)
      S_SCAN:  begin rd_row = last_idx; rd_col = j_q;      end
      S_RDA:   begin rd_row = prev_idx; rd_col = prev_idx; end
      S_RDB:   begin rd_row = last_idx; rd_col = prev_idx; end
      S_RDC:   begin rd_row = last_idx; rd_col = last_idx; end
      S_APPLY: begin rd_row = j_q;      rd_col = j_q;      end
      default: ;
    endcase
  end

  // next-state logic
  always_comb begin
    st_d = st_q; j_d = j_q; act_d = act_q;
    a_d = a_q; b_d = b_q; c_d = c_q; mu_d = mu_q;
    sub_d = sub_q; small_d = small_q; conv_d = conv_q; zden_d = zden_q;
    unique case (st_q)
      S_IDLE: if (start) begin
        sub_d = (cmd == CMD_SHIFT);
        j_d = '0; small_d = 1'b1;
        if (act_q <= AW'(1))        st_d = S_DONE;
        else if (cmd == CMD_SHIFT)  st_d = S_SCAN;
        else                        st_d = S_APPLY;
      end
      S_SCAN: begin
        if (j_q == prev_idx) begin
          if (small_q && is_small) begin
            act_d = act_q - AW'(1);
            if (act_q == AW'(2)) begin
              conv_d = 1'b1; st_d = S_DONE;
            end else st_d = S_RDA;
          end else st_d = S_RDA;
        end else begin
          j_d = j_q + 1'b1;
          small_d = small_q & is_small;
        end
      end
      S_RDA:  begin a_d = rd_data; st_d = S_RDB;  end
      S_RDB:  begin b_d = rd_data; st_d = S_RDC;  end
      S_RDC:  begin c_d = rd_data; st_d = S_PREP; end
      S_PREP: st_d = S_ROOT;
      S_ROOT: if (sq_done) begin
        zden_d = (den == '0);
        st_d   = (den == '0) ? S_MU : S_DIV;
      end
      S_DIV:  if (dv_done) st_d = S_MU;
      S_MU: begin
        mu_d = delta[W-1] ? c_q + $signed(qv) : c_q - $signed(qv);
        j_d  = '0;
        st_d = S_APPLY;
      end
      S_APPLY: begin
        if (j_q == last_idx) st_d = S_DONE;
        else j_d = j_q + 1'b1;
      end
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; j_q <= '0; act_q <= AW'(N);
      a_q <= '0; b_q <= '0; c_q <= '0; mu_q <= '0;
      sub_q <= 1'b0; small_q <= 1'b0; conv_q <= 1'b0; zden_q <= 1'b0;
    end else begin
      st_q <= st_d; j_q <= j_d; act_q <= act_d;
      a_q <= a_d; b_q <= b_d; c_q <= c_d; mu_q <= mu_d;
      sub_q <= sub_d; small_q <= small_d; conv_q <= conv_d; zden_q <= zden_d;
    end
  end

  assign wr_en    = (st_q == S_APPLY);
  assign wr_idx   = j_q;
  assign wr_data  = sub_q ? rd_data - mu_q : rd_data + mu_q;
  assign mu       = mu_q;
  assign act_size = act_q;
  assign all_conv = conv_q;
  assign busy     = (st_q != S_IDLE) && (st_q != S_DONE);
  assign done     = (st_q == S_DONE);
endmodule

// File: rtl/wk_shift_chk.sv
module wk_shift_chk #(
  parameter int N = 4,
  parameter int W = 32,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1,
  localparam int AW   = $clog2(N + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done,
  input logic            busy,
  input logic            all_conv,
  input logic [AW-1:0]   act_size,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  act_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (act_size == $past(act_size)) || (act_size == $past(act_size) - AW'(1)));

  // R8
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_conv |=> all_conv);

  // R8
  conv_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_conv |-> !wr_en);

  // R6
  wr_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (AW'(wr_idx) < act_size));

  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);
endmodule

bind wk_shift_unit wk_shift_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .all_conv(all_conv),
  .act_size(act_size), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/sim_wk_shift_unit.sv
`timescale 1ns/1ps
module sim_wk_shift_unit;
  localparam int N = 4;
  localparam int W = 32;

  logic clk, rst_n, start, cmd;
  logic [W-1:0] thr;
  logic [1:0] rd_row, rd_col, wr_idx;
  logic [W-1:0] rd_data, wr_data, mu;
  logic wr_en, all_conv, busy, done;
  logic [2:0] act_size;

  logic signed [W-1:0] mem [N][N];
  logic signed [W-1:0] expm [N][N];
  logic signed [W-1:0] orig [N][N];
  int checks = 0, errors = 0;
  int m_act;
  logic signed [W-1:0] m_mu;
  logic m_conv;
  bit finished = 0;

  initial clk = 0;
  always #10 clk = ~clk;

  assign rd_data = mem[rd_row][rd_col];
  always @(posedge clk) if (wr_en) mem[wr_idx][wr_idx] <= wr_data;

  wk_shift_unit #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .thr(thr),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .mu(mu),
    .act_size(act_size), .all_conv(all_conv), .busy(busy), .done(done)
  );

  task automatic chk(bit ok, string req, longint actv, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  function automatic longint isqrt(longint x);
    longint r = 0;
    for (int b = 31; b >= 0; b--) begin
      longint t = r | (64'sd1 <<< b);
      if (t * t <= x) r = t;
    end
    return r;
  endfunction

  function automatic logic signed [W-1:0] ref_mu(longint a, longint b, longint c);
    longint delta = (a - c) >>> 1;
    longint d2 = (delta * delta) >>> 16;
    longint b2 = (b * b) >>> 16;
    longint s = isqrt((d2 + b2) <<< 16);
    longint den = ((delta < 0) ? -delta : delta) + s;
    longint q;
    if (den == 0) return W'(c);
    q = (b2 <<< 16) / den;
    return (delta < 0) ? W'(c + q) : W'(c - q);
  endfunction

  function automatic longint rnd(int lim);
    return longint'($urandom_range(2 * lim)) - lim;
  endfunction

  task automatic do_reset();
    rst_n = 0; start = 0; cmd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    m_act = N; m_mu = '0; m_conv = 0;
  endtask

  task automatic set_sym(int r, int c, longint v);
    mem[r][c] = W'(v); mem[c][r] = W'(v);
  endtask

  // issue a command and wait for the done pulse; checks R9 handshake
  task automatic do_cmd(logic c);
    int n = 0;
    @(negedge clk); start = 1; cmd = c;
    @(negedge clk); start = 0;
    chk(busy === 1'b1 || done === 1'b1, "R9 busy after start", busy, 1);
    // a second start while busy must be ignored
    if (busy) begin start = 1; cmd = ~c; @(negedge clk); start = 0; end
    while (done !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk(done === 1'b1, "R9 done reached", done, 1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R9 done one cycle", done, 0);
  endtask

  task automatic cmp_all(string req);
    int bad = 0; longint av = 0, ev = 0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        if (mem[r][c] !== expm[r][c] && bad == 0) begin
          bad = 1; av = mem[r][c]; ev = expm[r][c];
        end
    chk(bad == 0, req, av, ev);
  endtask

  // model one shift command and check the outcome
  task automatic shift_and_check();
    int k = m_act;
    bit sm = 1;
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) begin
      orig[r][c] = mem[r][c]; expm[r][c] = mem[r][c];
    end
    if (k > 1) begin
      for (int j = 0; j < k - 1; j++) begin
        longint v = orig[k-1][j];
        if (v < 0) v = -v;
        if (!(v < longint'(thr))) sm = 0;
      end
      if (sm) k--;
      if (k == 1) m_conv = 1;
      else begin
        m_mu = ref_mu(orig[k-2][k-2], orig[k-1][k-2], orig[k-1][k-1]);
        for (int i = 0; i < k; i++) expm[i][i] = orig[i][i] - m_mu;
      end
    end
    m_act = k;
    do_cmd(1'b0);
    chk(act_size == 3'(m_act), "R2 active size", act_size, m_act);
    chk(all_conv == m_conv, "R8 all_conv", all_conv, m_conv);
    chk($signed(mu) == m_mu, "R4 shift value", $signed(mu), m_mu);
    cmp_all("R6 diagonal subtract");
  endtask

  task automatic restore_and_check();
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) expm[r][c] = mem[r][c];
    if (m_act > 1) for (int i = 0; i < m_act; i++) expm[i][i] = mem[i][i] + m_mu;
    do_cmd(1'b1);
    cmp_all("R7 diagonal restore");
    chk($signed(mu) == m_mu, "R7 mu kept", $signed(mu), m_mu);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    thr = '0;
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) mem[r][c] = '0;
    do_reset();
    // R1 reset state
    chk(act_size == 3'(N), "R1 act reset", act_size, N);
    chk(all_conv == 0 && done == 0 && busy == 0, "R1 flags reset", {all_conv, done, busy}, 0);
    chk(mu == 0, "R1 mu reset", mu, 0);

    // R5 delta zero: a=c=2.0, b=1.0 -> mu = 1.0 ; thr=0 blocks deflation
    for (int i = 0; i < N; i++) set_sym(i, i, 32'h0003_0000);
    set_sym(2, 2, 32'h0002_0000); set_sym(3, 3, 32'h0002_0000);
    set_sym(3, 2, 32'h0001_0000); set_sym(1, 0, 32'h0000_8000);
    shift_and_check();
    chk($signed(mu) == 32'sh0001_0000, "R5 zero delta sign", $signed(mu), 32'sh0001_0000);
    restore_and_check();

    // R5 zero denominator: a=c, b=0 -> mu = c
    do_reset();
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) mem[r][c] = '0;
    set_sym(3, 3, 32'h0004_0000); set_sym(2, 2, 32'h0004_0000);
    set_sym(0, 0, 32'h0001_0000);
    shift_and_check();
    chk($signed(mu) == 32'sh0004_0000, "R5 zero denominator", $signed(mu), 32'sh0004_0000);
    restore_and_check();

    // R3 deflation then shift from the 3x3 region
    do_reset();
    thr = 32'h0000_0100;
    for (int r = 0; r < N; r++) for (int c = r; c < N; c++) set_sym(r, c, rnd(1 << 19));
    set_sym(3, 0, 5); set_sym(3, 1, -32'sd7); set_sym(3, 2, 32'h80);
    shift_and_check();
    chk(act_size == 3'd3, "R3 deflated region", act_size, 3);
    restore_and_check();

    // R8 walk an all-zero matrix down to convergence
    do_reset();
    thr = 32'h1;
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) mem[r][c] = '0;
    set_sym(0, 0, 32'h0002_0000); set_sym(1, 1, 32'h0003_0000);
    for (int s = 0; s < N; s++) begin
      shift_and_check();
      restore_and_check();
    end
    chk(all_conv == 1'b1, "R8 converged", all_conv, 1);
    chk(act_size == 3'd1, "R8 size one", act_size, 1);

    // random trials
    do_reset();
    for (int t = 0; t < 120; t++) begin
      if (m_act == 1) do_reset();
      thr = ($urandom_range(3) == 0) ? 32'h0 : 32'h0000_0200;
      for (int r = 0; r < N; r++) for (int c = r; c < N; c++) set_sym(r, c, rnd(1 << 20));
      if ($urandom_range(1) == 1 && m_act > 1)
        for (int j = 0; j < m_act - 1; j++) set_sym(m_act - 1, j, rnd(32'h1ff));
      if ($urandom_range(7) == 0 && m_act > 1)
        set_sym(m_act - 2, m_act - 2, longint'(mem[m_act-1][m_act-1]));
      shift_and_check();
      restore_and_check();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule